// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Engine

This block drives a single-conductor, open-drain, half-duplex serial bus on which it is the only master. The line idles high through an external pull-up; the block can only pull it low or let it go. On command it produces one of four line waveforms: a long reset pulse followed by a listen window for a device answer, a short-low slot that writes a 1, a long-low slot that writes a 0, and a read slot that looks like a write-1 slot but samples the line part-way through.

All timing is counted in microseconds, derived from the system clock by a prescaler that restarts when a command is taken. The block takes a command only while idle, holds busy for its whole length, and at the end pulses done for one cycle together with its result: whether a device answered the reset, or the bit read. A byte-level wrapper can issue eight slots in a row, least significant bit first.

Top module: `owm_master`

## Requirements
- R1: After reset, bus_pull, busy and done are low, and presence and read_bit are 0.
- R2: With busy low, cmd_valid high at a clock edge takes the command cmd_op (2'b00 reset, 2'b01 write-0, 2'b10 write-1, 2'b11 read); busy is high from that edge until the edge on which done rises, and low in the cycle done is high.
- R3: A write-1 command pulls the line low for exactly 6 µs from acceptance and signals done 62 µs after acceptance (60 µs slot plus 2 µs recovery).
- R4: A write-0 command pulls the line low for exactly 60 µs and signals done 62 µs after acceptance.
- R5: A read command pulls the line low for 6 µs, samples bus_in at 14 µs after acceptance, and signals done at 62 µs with read_bit 1 if the line was high and 0 if it was low.
- R6: A reset command pulls the line low for 480 µs, samples bus_in 70 µs after release, and signals done 480 µs after release; presence is 1 if the line was low at the sample and 0 otherwise.
- R7: done is a one-cycle pulse; presence changes only at the end of a reset command and read_bit only at the end of a read command, holding their values otherwise.
- R8: cmd_valid while busy is high is ignored: the running command keeps its waveform and timing.
- R9: One microsecond equals CLK_PER_US clock cycles, counted from the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request, taken only while idle |
| cmd_op | input | 2 | Command code: 00 reset, 01 write-0, 10 write-1, 11 read |
| bus_in | input | 1 | Level of the bus line as seen by the master |
| bus_pull | output | 1 | 1 drives the line low, 0 releases it |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse at the end of a command |
| presence | output | 1 | A device answered the last reset |
| read_bit | output | 1 | Bit sampled in the last read slot |

## Verification
Reset is run once with an emulated device answering inside the listen window and once with the line left high, which separates a correct presence sample from a stuck value. Read slots are run with the device holding the line low across the sample point and with the line released, so a mis-placed sample or inverted bit shows. Write-0 and write-1 slots differ only in low time, so measuring low cycles and total cycles in both separates the two lengths, and a command pushed in mid-slot plus a write following a read show that busy requests and unrelated completions leave the running timing and held results alone.

// File: rtl/owm_pkg.sv
package owm_pkg;
    typedef enum logic [1:0] {
        OP_RESET = 2'b00,
        OP_WR0   = 2'b01,
        OP_WR1   = 2'b10,
        OP_READ  = 2'b11
    } op_e;
endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
    parameter int CLK_PER_US = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        if (restart || pre_q == LAST) pre_d = '0;
        else                          pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = (pre_q == LAST);

    initial begin
        a_div_min_r9: assert (CLK_PER_US >= 2);
    end

    p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/owm_seq.sv
module owm_seq
    import owm_pkg::*;
#(
    parameter int T_RST_LOW  = 480,
    parameter int T_PRES_SMP = 70,
    parameter int T_RST_REC  = 480,
    parameter int T_SLOT     = 60,
    parameter int T_RECOV    = 2,
    parameter int T_W1_LOW   = 6,
    parameter int T_W0_LOW   = 60,
    parameter int T_RD_LOW   = 6,
    parameter int T_RD_SMP   = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       bus_in,
    output logic       start,
    output logic       bus_pull,
    output logic       busy,
    output logic       done,
    output logic       presence,
    output logic       read_bit
);
    localparam int RST_END  = T_RST_LOW + T_RST_REC;
    localparam int SLOT_END = T_SLOT + T_RECOV;
    localparam int US_W     = $clog2(RST_END + 1);

    localparam logic [US_W-1:0] RST_LOW_L  = US_W'(T_RST_LOW);
    localparam logic [US_W-1:0] RST_SMP_M1 = US_W'(T_RST_LOW + T_PRES_SMP - 1);
    localparam logic [US_W-1:0] RST_END_M1 = US_W'(RST_END - 1);
    localparam logic [US_W-1:0] SLT_END_M1 = US_W'(SLOT_END - 1);
    localparam logic [US_W-1:0] RD_SMP_M1  = US_W'(T_RD_SMP - 1);
    localparam logic [US_W-1:0] W1_LOW_L   = US_W'(T_W1_LOW);
    localparam logic [US_W-1:0] W0_LOW_L   = US_W'(T_W0_LOW);
    localparam logic [US_W-1:0] RD_LOW_L   = US_W'(T_RD_LOW);

    typedef struct packed {
        logic            active;
        op_e             op;
        logic [US_W-1:0] us;
        logic            smp;
        logic            done;
        logic            pres;
        logic            rbit;
    } st_t;

    st_t q, d;
    logic [US_W-1:0] low_len, smp_m1, end_m1;

    // Per-command timing limits, selected from the latched command
    always_comb begin
        unique case (q.op)
            OP_RESET: begin low_len = RST_LOW_L; smp_m1 = RST_SMP_M1; end_m1 = RST_END_M1; end
            OP_WR0:   begin low_len = W0_LOW_L;  smp_m1 = RD_SMP_M1;  end_m1 = SLT_END_M1; end
            OP_WR1:   begin low_len = W1_LOW_L;  smp_m1 = RD_SMP_M1;  end_m1 = SLT_END_M1; end
            default:  begin low_len = RD_LOW_L;  smp_m1 = RD_SMP_M1;  end_m1 = SLT_END_M1; end
        endcase
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        start  = 1'b0;
        if (!q.active) begin
            if (cmd_valid) begin
                start    = 1'b1;
                d.active = 1'b1;
                d.op     = op_e'(cmd_op);
                d.us     = '0;
            end
        end else if (tick) begin
            if (q.us == smp_m1) d.smp = bus_in;
            if (q.us == end_m1) begin
                d.active = 1'b0;
                d.done   = 1'b1;
                if (q.op == OP_RESET) d.pres = ~q.smp;
                if (q.op == OP_READ)  d.rbit = q.smp;
            end else begin
                d.us = q.us + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{active: 1'b0, op: OP_RESET, us: '0, smp: 1'b1,
                   done: 1'b0, pres: 1'b0, rbit: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign bus_pull = q.active && (q.us < low_len);
    assign busy     = q.active;
    assign done     = q.done;
    assign presence = q.pres;
    assign read_bit = q.rbit;

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> !q.active);
    p_hold_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && !tick) |=> (q.active && $stable(q.op) && $stable(q.us)));
    p_pres_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.op != OP_RESET) |-> $stable(q.pres));
    p_rbit_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.op != OP_READ) |-> $stable(q.rbit));
endmodule

// File: rtl/owm_master.sv
module owm_master #(
    parameter int CLK_PER_US = 250,
    parameter int T_RST_LOW  = 480,
    parameter int T_PRES_SMP = 70,
    parameter int T_RST_REC  = 480,
    parameter int T_SLOT     = 60,
    parameter int T_RECOV    = 2,
    parameter int T_W1_LOW   = 6,
    parameter int T_W0_LOW   = 60,
    parameter int T_RD_LOW   = 6,
    parameter int T_RD_SMP   = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       bus_in,
    output logic       bus_pull,
    output logic       busy,
    output logic       done,
    output logic       presence,
    output logic       read_bit
);
    logic tick, start;

    owm_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .tick    (tick)
    );

    owm_seq #(
        .T_RST_LOW (T_RST_LOW),  .T_PRES_SMP(T_PRES_SMP), .T_RST_REC(T_RST_REC),
        .T_SLOT    (T_SLOT),     .T_RECOV   (T_RECOV),    .T_W1_LOW (T_W1_LOW),
        .T_W0_LOW  (T_W0_LOW),   .T_RD_LOW  (T_RD_LOW),   .T_RD_SMP (T_RD_SMP)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .bus_in    (bus_in),
        .start     (start),
        .bus_pull  (bus_pull),
        .busy      (busy),
        .done      (done),
        .presence  (presence),
        .read_bit  (read_bit)
    );
endmodule

// File: tb/owm_master_bench.sv
module owm_master_bench;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic bus_in;
    logic bus_pull, busy, done, presence, read_bit;
    logic slave_low = 1'b0;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    assign bus_in = !(bus_pull || slave_low);

    owm_master #(.CLK_PER_US(N)) u_owm_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .bus_in(bus_in), .bus_pull(bus_pull), .busy(busy), .done(done),
        .presence(presence), .read_bit(read_bit)
    );

    // Behavioural reference: microsecond figures from the requirements
    function automatic int low_us(input logic [1:0] op);
        case (op)
            2'b00:   return 480;
            2'b01:   return 60;
            default: return 6;
        endcase
    endfunction
    function automatic int end_us(input logic [1:0] op);
        return (op == 2'b00) ? 960 : 62;
    endfunction

    bit m_busy = 0, m_done = 0;
    int m_cyc = 0;
    logic [1:0] m_op = 2'b00;

    always @(posedge clk) begin
        m_done = 0;
        if (!rst_n) begin
            m_busy = 0; m_cyc = 0;
        end else if (m_busy) begin
            m_cyc++;
            if (m_cyc == end_us(m_op) * N) begin m_busy = 0; m_done = 1; end
        end else if (cmd_valid) begin
            m_busy = 1; m_cyc = 0; m_op = cmd_op;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    bit run_cmp = 0;
    always @(negedge clk) begin
        if (run_cmp) begin
            bit ep;
            ep = m_busy && (m_cyc < low_us(m_op) * N);
            if (bus_pull !== ep)
                check(0, $sformatf("R3/R4/R5/R6 pull op=%0d cyc=%0d", m_op, m_cyc), bus_pull, ep);
            if (busy !== m_busy) check(0, "R2 busy", busy, m_busy);
            if (done !== m_done) check(0, "R7 done pulse", done, m_done);
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Issue one command, emulate the device, measure low time and length
    task automatic run_op(input logic [1:0] op, input bit slave_act, input bit inject,
                          input string tag);
        int lowc, tot;
        lowc = 0; tot = 0;
        @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk); cmd_valid = 1'b0;
        fork
            begin
                while (!done && tot < 5000 * N) begin
                    if (bus_pull) lowc++;
                    tot++;
                    @(negedge clk);
                end
            end
            begin
                if (inject) begin
                    repeat (10 * N) @(negedge clk);
                    cmd_valid = 1'b1; cmd_op = 2'b00;
                    @(negedge clk); cmd_valid = 1'b0;
                end
                if (slave_act && op == 2'b00) begin
                    repeat (500 * N) @(negedge clk);
                    slave_low = 1'b1;
                    repeat (100 * N) @(negedge clk);
                    slave_low = 1'b0;
                end
                if (slave_act && op == 2'b11) begin
                    repeat (2 * N) @(negedge clk);
                    slave_low = 1'b1;
                    repeat (28 * N) @(negedge clk);
                    slave_low = 1'b0;
                end
            end
        join
        check(lowc == low_us(op) * N, {tag, " low time"}, lowc, low_us(op) * N);
        check(tot == end_us(op) * N, {tag, " length R9"}, tot, end_us(op) * N);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(bus_pull == 0 && busy == 0 && done == 0, "R1 idle outputs", {bus_pull, busy, done}, 0);
        check(presence == 0 && read_bit == 0, "R1 results", {presence, read_bit}, 0);
        rst_n = 1'b1;
        run_cmp = 1;

        run_op(2'b00, 1, 0, "R6 reset present");
        check(presence == 1, "R6 presence with device", presence, 1);
        run_op(2'b00, 0, 0, "R6 reset absent");
        check(presence == 0, "R6 presence without device", presence, 0);
        run_op(2'b10, 0, 0, "R3 write-1");
        run_op(2'b01, 0, 1, "R4 write-0 with busy request R8");
        check(presence == 0, "R8 ignored reset left presence", presence, 0);
        run_op(2'b11, 0, 0, "R5 read released");
        check(read_bit == 1, "R5 read high", read_bit, 1);
        run_op(2'b11, 1, 0, "R5 read device low");
        check(read_bit == 0, "R5 read low", read_bit, 0);
        run_op(2'b00, 1, 0, "R6 reset present again");
        check(read_bit == 0, "R7 read_bit held over reset", read_bit, 0);
        run_op(2'b10, 0, 1, "R3 write-1 with busy request R8");
        check(presence == 1, "R7 presence held over write", presence, 1);
        check(read_bit == 0, "R7 read_bit held over write", read_bit, 0);
        @(negedge clk);
        check(done == 0, "R7 done one cycle", done, 0);
        check(busy == 0 && bus_pull == 0, "R2 idle after command", {busy, bus_pull}, 0);

        run_cmp = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule